// File: doc/BRIEF.md
# Rectangle Fill Request Generator

This block paints a rectangular window of a frame buffer with a single constant colour. Software-side logic loads a start byte address, a line gap counted in pixels, a pixels-per-line count, a line count, a colour word and a 3-bit colour mode, then pulses start. The block emits one write request per pixel, in row-major order, over a valid/ready handshake. Each request carries a byte address, a data word and a byte count.

The colour mode sets the pixel size in bytes and how much of the colour word is sent. Inside a line the address grows by one pixel size per accepted request. At the end of a line the address skips over the gap before the next line begins. When the last request has been accepted, the block drops busy and pulses done. Packing into bus words, the bus protocol itself, source reads and blending are left to the neighbouring logic.

Top module: `rectFillGen`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done` and `reqValid` are low until a start is accepted.
- R2: A start pulse seen while idle, with non-zero dimensions, raises `busy` and `reqValid` in the next cycle. The first request addresses the start address.
- R3: `reqSize` follows the colour mode: code 0 gives 4, code 1 gives 3, codes 2, 3 and 4 give 2. The unused codes 5 to 7 are treated like code 0 and give 4.
- R4: `reqData` is the colour word unchanged for a 4-byte mode, its low 24 bits zero-extended for code 1, and its low 16 bits zero-extended for the 2-byte codes.
- R5: Within a line, each accepted request moves the address on by `reqSize` bytes.
- R6: The first pixel of a line is at the last pixel address of the previous line plus `reqSize × (1 + gap)`.
- R7: Exactly pixels-per-line × lines requests are issued, line by line.
- R8: A start with a pixel count of 0 or a line count of 0 produces a `done` pulse in the next cycle. No request is issued and `busy` stays low.
- R9: `done` is high for exactly one cycle, in the cycle after the final request is accepted. In that same cycle `busy` and `reqValid` are low.
- R10: Start pulses while busy are ignored. This includes a pulse in the same cycle as the final acceptance.
- R11: While `reqValid` is high and `reqReady` is low, the request is held unchanged.
- R12: The configuration is captured at start. Changes to the configuration inputs during a fill have no effect on the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begin a fill |
| cfgAddr | input | ADDR_W | Byte address of the first pixel |
| cfgGap | input | GAP_W | Pixels skipped after each line |
| cfgPixPerLine | input | PPL_W | Pixels in each line |
| cfgLines | input | LINES_W | Number of lines |
| cfgColor | input | 32 | Fill colour word |
| cfgMode | input | 3 | Colour mode code |
| reqValid | output | 1 | Write request is present |
| reqReady | input | 1 | Consumer takes the request |
| reqAddr | output | ADDR_W | Request byte address |
| reqData | output | 32 | Request data, zero-extended |
| reqSize | output | 3 | Request byte count (2, 3 or 4) |
| busy | output | 1 | Fill in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two events can meet in one cycle: acceptance of the last pixel and a new start pulse. The bench provokes this by driving start together with the final ready. It expects the fill to end with a `done` pulse, `busy` low, and no second fill in the cycle that follows. Random start pulses and scrambled configuration inputs during a fill, together with random back-pressure, must leave the address sequence computed by the bench's model unchanged.

// File: rtl/rectFillPkg.sv
package rectFillPkg;

  typedef struct packed {
    logic load;   // capture configuration, first pixel
    logic step;   // next pixel in the same line
    logic wrap;   // jump to the first pixel of the next line
  } fillStrobes_t;

  typedef enum logic {
    S_IDLE = 1'b0,
    S_RUN  = 1'b1
  } fillState_t;

  function automatic logic [2:0] pixBytes(input logic [2:0] mode);
    case (mode)
      3'd1:                pixBytes = 3'd3;
      3'd2, 3'd3, 3'd4:    pixBytes = 3'd2;
      default:             pixBytes = 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] fillWord(input logic [31:0] color, input logic [2:0] mode);
    case (mode)
      3'd1:                fillWord = {8'h00, color[23:0]};
      3'd2, 3'd3, 3'd4:    fillWord = {16'h0000, color[15:0]};
      default:             fillWord = color;
    endcase
  endfunction

endpackage

// File: rtl/rectFillDatapath.sv
module rectFillDatapath
  import rectFillPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int GAP_W   = 14,
  parameter int PPL_W   = 14,
  parameter int LINES_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  fillStrobes_t       strobes,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [GAP_W-1:0]   cfgGap,
  input  logic [PPL_W-1:0]   cfgPixPerLine,
  input  logic [LINES_W-1:0] cfgLines,
  input  logic [31:0]        cfgColor,
  input  logic [2:0]         cfgMode,
  output logic               zeroDims,
  output logic               lastPix,
  output logic               lastLine,
  output logic [ADDR_W-1:0]  curAddr,
  output logic [31:0]        curData,
  output logic [2:0]         curSize
);

  localparam int GAPX_W = GAP_W + 3;

  logic [PPL_W-1:0]   pplReg;
  logic [PPL_W-1:0]   pixLeft;
  logic [LINES_W-1:0] linesLeft;
  logic [ADDR_W-1:0]  lineJump;
  logic [GAPX_W-1:0]  gapBytes;
  logic [GAPX_W-1:0]  gapExt;
  logic [ADDR_W-1:0]  sizeExt;

  assign zeroDims = (cfgPixPerLine == '0) || (cfgLines == '0);
  assign lastPix  = (pixLeft == PPL_W'(1));
  assign lastLine = (linesLeft == LINES_W'(1));
  assign gapExt   = GAPX_W'(cfgGap);
  assign sizeExt  = ADDR_W'(curSize);

  // gap in bytes = gap pixels times pixel size (2, 3 or 4)
  always_comb begin
    case (pixBytes(cfgMode))
      3'd3:    gapBytes = (gapExt << 1) + gapExt;
      3'd2:    gapBytes = gapExt << 1;
      default: gapBytes = gapExt << 2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pplReg    <= '0;
      pixLeft   <= '0;
      linesLeft <= '0;
      lineJump  <= '0;
      curAddr   <= '0;
      curData   <= '0;
      curSize   <= 3'd4;
    end else if (strobes.load) begin
      pplReg    <= cfgPixPerLine;
      pixLeft   <= cfgPixPerLine;
      linesLeft <= cfgLines;
      lineJump  <= ADDR_W'(gapBytes) + ADDR_W'(pixBytes(cfgMode));
      curAddr   <= cfgAddr;
      curData   <= fillWord(cfgColor, cfgMode);
      curSize   <= pixBytes(cfgMode);
    end else if (strobes.wrap) begin
      pixLeft   <= pplReg;
      linesLeft <= linesLeft - LINES_W'(1);
      curAddr   <= curAddr + lineJump;
    end else if (strobes.step) begin
      pixLeft   <= pixLeft - PPL_W'(1);
      curAddr   <= curAddr + sizeExt;
    end
  end

endmodule

// File: rtl/rectFillControl.sv
module rectFillControl
  import rectFillPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startPulse,
  input  logic         reqReady,
  input  logic         zeroDims,
  input  logic         lastPix,
  input  logic         lastLine,
  output fillStrobes_t strobes,
  output logic         running,
  output logic         donePulse
);

  fillState_t state;
  logic       accept;
  logic       finish;
  logic       launch;

  assign running = (state == S_RUN);
  assign accept  = running && reqReady;
  assign finish  = accept && lastPix && lastLine;
  assign launch  = (state == S_IDLE) && startPulse;

  always_comb begin
    strobes      = '0;
    strobes.load = launch && !zeroDims;
    strobes.wrap = accept && lastPix && !lastLine;
    strobes.step = accept && !lastPix;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      donePulse <= 1'b0;
    end else begin
      donePulse <= finish || (launch && zeroDims);
      if (strobes.load)  state <= S_RUN;
      else if (finish)   state <= S_IDLE;
    end
  end

endmodule

// File: rtl/rectFillGen.sv
module rectFillGen
  import rectFillPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int GAP_W   = 14,
  parameter int PPL_W   = 14,
  parameter int LINES_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [GAP_W-1:0]   cfgGap,
  input  logic [PPL_W-1:0]   cfgPixPerLine,
  input  logic [LINES_W-1:0] cfgLines,
  input  logic [31:0]        cfgColor,
  input  logic [2:0]         cfgMode,
  output logic               reqValid,
  input  logic               reqReady,
  output logic [ADDR_W-1:0]  reqAddr,
  output logic [31:0]        reqData,
  output logic [2:0]         reqSize,
  output logic               busy,
  output logic               done
);

  fillStrobes_t strobes;
  logic zeroDims;
  logic lastPix;
  logic lastLine;
  logic running;

  rectFillControl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .reqReady   (reqReady),
    .zeroDims   (zeroDims),
    .lastPix    (lastPix),
    .lastLine   (lastLine),
    .strobes    (strobes),
    .running    (running),
    .donePulse  (done)
  );

  rectFillDatapath #(
    .ADDR_W  (ADDR_W),
    .GAP_W   (GAP_W),
    .PPL_W   (PPL_W),
    .LINES_W (LINES_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .cfgAddr       (cfgAddr),
    .cfgGap        (cfgGap),
    .cfgPixPerLine (cfgPixPerLine),
    .cfgLines      (cfgLines),
    .cfgColor      (cfgColor),
    .cfgMode       (cfgMode),
    .zeroDims      (zeroDims),
    .lastPix       (lastPix),
    .lastLine      (lastLine),
    .curAddr       (reqAddr),
    .curData       (reqData),
    .curSize       (reqSize)
  );

  assign reqValid = running;
  assign busy     = running;

endmodule

// File: rtl/rectFillGenChecker.sv
module rectFillGenChecker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [31:0]       reqData,
  input logic [2:0]        reqSize,
  input logic              busy,
  input logic              done
);

  p_launch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startPulse) |=> (busy || done));

  p_size_legal_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqSize == 3'd2 || reqSize == 3'd3 || reqSize == 3'd4));

  p_addr_moves_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (!reqValid || reqAddr != $past(reqAddr)));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !reqValid));

  p_busy_holds_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(reqValid && reqReady)) |=> busy);

  p_hold_on_stall_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqReady) |=> (reqValid && $stable(reqAddr) && $stable(reqData) && $stable(reqSize)));

  p_color_fixed_r12: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!busy || ($stable(reqData) && $stable(reqSize))));

endmodule

bind rectFillGen rectFillGenChecker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqAddr    (reqAddr),
  .reqData    (reqData),
  .reqSize    (reqSize),
  .busy       (busy),
  .done       (done)
);

// File: tb/rectFillGen_tb.sv
module rectFillGen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [31:0] cfgAddr = '0;
  logic [13:0] cfgGap = '0;
  logic [13:0] cfgPixPerLine = '0;
  logic [15:0] cfgLines = '0;
  logic [31:0] cfgColor = '0;
  logic [2:0]  cfgMode = '0;
  logic        reqValid;
  logic        reqReady = 1'b0;
  logic [31:0] reqAddr;
  logic [31:0] reqData;
  logic [2:0]  reqSize;
  logic        busy;
  logic        done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  rectFillGen u_dut (
    .clk           (clk),
    .rstN          (rstN),
    .startPulse    (startPulse),
    .cfgAddr       (cfgAddr),
    .cfgGap        (cfgGap),
    .cfgPixPerLine (cfgPixPerLine),
    .cfgLines      (cfgLines),
    .cfgColor      (cfgColor),
    .cfgMode       (cfgMode),
    .reqValid      (reqValid),
    .reqReady      (reqReady),
    .reqAddr       (reqAddr),
    .reqData       (reqData),
    .reqSize       (reqSize),
    .busy          (busy),
    .done          (done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, cycles=%0d expected<=%0d", cycles, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [2:0] expSize(input logic [2:0] m);
    case (m)
      3'd1:             expSize = 3'd3;
      3'd2, 3'd3, 3'd4: expSize = 3'd2;
      default:          expSize = 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] expData(input logic [31:0] c, input logic [2:0] m);
    case (m)
      3'd1:             expData = {8'h00, c[23:0]};
      3'd2, 3'd3, 3'd4: expData = {16'h0000, c[15:0]};
      default:          expData = c;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // runs one fill and checks every request against the bench model
  task automatic doFill(input logic [31:0] addr, input logic [13:0] gap,
                        input logic [13:0] ppl, input logic [15:0] nl,
                        input logic [31:0] color, input logic [2:0] mode,
                        input bit collide, input bit noisy, input int stallPct);
    logic [31:0] lineStart;
    logic [31:0] expAddr;
    logic [2:0]  sz;
    bit          stalled;
    sz = expSize(mode);
    @(negedge clk);
    cfgAddr = addr; cfgGap = gap; cfgPixPerLine = ppl; cfgLines = nl;
    cfgColor = color; cfgMode = mode; startPulse = 1'b1; reqReady = 1'b0;
    @(negedge clk);
    startPulse = 1'b0;
    if (ppl == 0 || nl == 0) begin
      chk(done && !busy && !reqValid, "R8", "done/busy/valid after empty start",
          {29'd0, done, busy, reqValid}, 32'h4);
      @(negedge clk);
      chk(!done && !busy && !reqValid, "R8", "quiet after empty fill",
          {29'd0, done, busy, reqValid}, 32'h0);
      return;
    end
    chk(busy && reqValid, "R2", "busy/valid after start", {30'd0, busy, reqValid}, 32'h3);
    chk(reqAddr == addr, "R2", "first address", reqAddr, addr);
    if (noisy) begin
      // R12: scramble configuration mid-fill
      cfgAddr = $urandom; cfgGap = 14'($urandom); cfgPixPerLine = 14'($urandom);
      cfgLines = 16'($urandom); cfgColor = $urandom; cfgMode = 3'($urandom);
    end
    lineStart = addr;
    for (int l = 0; l < int'(nl); l++) begin
      for (int p = 0; p < int'(ppl); p++) begin
        expAddr = lineStart + 32'(p) * 32'(sz);
        stalled = 1'b0;
        forever begin
          chk(reqValid, stalled ? "R11" : "R7", "request valid", {31'd0, reqValid}, 32'h1);
          chk(reqAddr == expAddr,
              stalled ? "R11" : ((p == 0 && l > 0) ? "R6" : "R5"),
              "address", reqAddr, expAddr);
          chk(reqData == expData(color, mode), noisy ? "R12" : "R4", "data",
              reqData, expData(color, mode));
          chk(reqSize == sz, "R3", "size", {29'd0, reqSize}, {29'd0, sz});
          reqReady = (($urandom % 100) >= 32'(stallPct));
          startPulse = noisy ? 1'($urandom) : 1'b0;   // R10 stray starts
          if (collide && l == int'(nl) - 1 && p == int'(ppl) - 1 && reqReady)
            startPulse = 1'b1;
          @(negedge clk);
          if (reqReady) break;
          stalled = 1'b1;
        end
      end
      lineStart = lineStart + 32'(ppl) * 32'(sz) + 32'(gap) * 32'(sz);
    end
    startPulse = 1'b0;
    reqReady = 1'b0;
    chk(done && !busy && !reqValid, collide ? "R10" : "R9", "end of fill",
        {29'd0, done, busy, reqValid}, 32'h4);
    @(negedge clk);
    chk(!done && !busy && !reqValid, collide ? "R10" : "R9", "after done pulse",
        {29'd0, done, busy, reqValid}, 32'h0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done && !reqValid, "R1", "during reset",
        {29'd0, busy, done, reqValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !reqValid, "R1", "after reset",
        {29'd0, busy, done, reqValid}, 32'h0);

    // directed corners
    doFill(32'h1000, 14'd0, 14'd0, 16'd3, 32'hAABBCCDD, 3'd0, 1'b0, 1'b0, 0); // R8
    doFill(32'h2000, 14'd2, 14'd4, 16'd0, 32'hAABBCCDD, 3'd1, 1'b0, 1'b0, 0); // R8
    doFill(32'h3000, 14'd0, 14'd1, 16'd1, 32'h11223344, 3'd0, 1'b0, 1'b0, 0); // 1x1
    for (int m = 0; m < 8; m++)                                              // R3 R4
      doFill(32'h4000 + 32'(m) * 32'h100, 14'd3, 14'd3, 16'd2, 32'hF1E2D3C4,
             3'(m), 1'b0, 1'b0, 30);
    doFill(32'h5000, 14'd1, 14'd3, 16'd3, 32'h01020304, 3'd2, 1'b1, 1'b0, 0); // R10 collide
    doFill(32'h5800, 14'd2, 14'd2, 16'd2, 32'h0A0B0C0D, 3'd1, 1'b1, 1'b1, 50); // R10 R12

    // constrained random fills
    for (int i = 0; i < 40; i++) begin
      doFill($urandom & 32'h00FF_FFFC, 14'($urandom % 6), 14'($urandom % 7),
             16'($urandom % 5), $urandom, 3'($urandom % 8),
             1'($urandom), 1'($urandom), int'($urandom % 60));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule